// File: doc/BRIEF.md
# Byte-wide serial port register front end

This block is the register face of a small serial port. A host reaches it through a one-cycle select strobe with a byte data path. Every register sits on its own 32-bit word address and only carries 8 bits. The map holds four fixed identification bytes, a data port, a combined status and control register, and the two halves of a 16-bit baud divisor. Writing the data port fills a one-character transmit holding register. The holding register feeds an 8N1 shifter that drives the serial output. Reading the data port takes the oldest byte from a receive FIFO. A separate sampling block fills that FIFO through a valid strobe.

The status register holds three kinds of bits: flags the hardware sets, interrupt enables the host owns, and two sticky error bits. The host clears an error bit by writing a zero to it. The receive and transmit interrupt causes are combined onto one interrupt line. The divisor sets the transmit bit time. Each bit lasts four ticks, and one tick lasts divisor + 1 clock cycles. Software therefore loads the divisor as clk/(baud*4) - 1.

Top module: `sio_regfile`

## Requirements
- R1: After reset the status register reads 0xA0 (transmit empty and receive empty set, all other bits 0), both divisor bytes read 0, `irq_o` is 0 and `txd_o` is 1.
- R2: Byte addresses 0, 4, 8 and 12 return the parameters `ID0`..`ID3`. Writes to these addresses have no effect.
- R3: Address 24 holds divisor bits 7:0 and address 28 holds divisor bits 15:8. Both are read/write. Addresses at 32 and above read 0 and ignore writes. Address bits 1:0 are ignored.
- R4: A transmitted character is a start bit of 0, then 8 data bits LSB first, then a stop bit of 1. Each bit lasts 4*(divisor+1) clock cycles. The line is 1 when idle.
- R5: Status bit 7 (transmit empty) is 1 exactly when the one-entry holding register can take a byte. A write to address 16 while it is 0 is dropped.
- R6: The receive FIFO is 4 entries deep and first-in first-out. A read of address 16 returns and removes the oldest byte. When the FIFO is empty the same read returns 0 and removes nothing. Status bit 5 means empty, bit 3 means full, and bit 4 means exactly one free slot.
- R7: A received byte that arrives while the FIFO is full is discarded and sets status bit 1 (overrun).
- R8: A received byte flagged with a framing error is stored normally and sets status bit 0 (framing error).
- R9: A write to address 20 loads bit 2 (receive interrupt enable) and bit 6 (transmit interrupt enable). It clears bit 0 or bit 1 where the written bit is 0 and keeps it where the written bit is 1. Bits 3, 4, 5 and 7 are unaffected by the write.
- R10: `irq_o` is 1 when either of two conditions holds. The first is receive enable set with the FIFO non-empty or an error bit set. The second is transmit enable set with transmit empty set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| rx_valid_i | input | 1 | Received byte strobe from the sampling block |
| rx_data_i | input | 8 | Received byte |
| rx_ferr_i | input | 1 | Framing error flag for the received byte |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that `sel_i` only marks one access per cycle. They also assume that the receive strobe is a single-cycle pulse for each byte and that the divisor does not change while a character is being shifted. The bench drives every bus access and receive pulse for one full cycle, starting at a falling clock edge. It changes the divisor only after the serial line has gone idle and the scoreboard queue has drained. Reads are sampled before the rising edge that performs the pop.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DIV_W = 16;

  // word slot = byte address / 4
  localparam logic [2:0] SLOT_ID0   = 3'd0;
  localparam logic [2:0] SLOT_ID1   = 3'd1;
  localparam logic [2:0] SLOT_ID2   = 3'd2;
  localparam logic [2:0] SLOT_ID3   = 3'd3;
  localparam logic [2:0] SLOT_DATA  = 3'd4;
  localparam logic [2:0] SLOT_STAT  = 3'd5;
  localparam logic [2:0] SLOT_BAUDL = 3'd6;
  localparam logic [2:0] SLOT_BAUDH = 3'd7;

  // status bit positions
  localparam int ST_FERR  = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_RXIE  = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_ROOM1 = 4;
  localparam int ST_RXEMP = 5;
  localparam int ST_TXIE  = 6;
  localparam int ST_TXEMP = 7;

  localparam int BITS_PER_FRAME = 10;
  localparam int TICKS_PER_BIT  = 4;
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  // counter restarts whenever idle so every frame starts phase-aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift
  import sio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       tick_i,
  output logic       busy_o,
  output logic       txd_o
);
  localparam int SUB_W = $clog2(TICKS_PER_BIT);
  localparam int BIT_W = $clog2(BITS_PER_FRAME);

  logic                      busy_q;
  logic [BITS_PER_FRAME-1:0] sh_q;
  logic [SUB_W-1:0]          sub_q;
  logic [BIT_W-1:0]          bit_q;
  logic                      bit_end;

  assign bit_end = tick_i && (sub_q == SUB_W'(TICKS_PER_BIT - 1));
  assign busy_o  = busy_q;
  assign txd_o   = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      sub_q  <= '0;
      bit_q  <= '0;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, data_i, 1'b0};
        sub_q  <= '0;
        bit_q  <= '0;
      end
    end else if (tick_i) begin
      sub_q <= sub_q + 1'b1;
      if (bit_end) begin
        sh_q  <= {1'b1, sh_q[BITS_PER_FRAME-1:1]};
        bit_q <= bit_q + 1'b1;
        if (bit_q == BIT_W'(BITS_PER_FRAME - 1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [7:0]       data_i,
  input  logic             pop_i,
  output logic [7:0]       head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             room1_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign room1_o = (cnt_q == CNT_W'(DEPTH - 1));
  assign count_o = cnt_q;
  assign head_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[i] <= '0;
      else if (do_push && wp_q == PTR_W'(i)) mem_q[i] <= data_i;
    end
  end
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int         ADDR_W     = 6,
  parameter int         FIFO_DEPTH = 4,
  parameter logic [7:0] ID0        = 8'h5A,
  parameter logic [7:0] ID1        = 8'h10,
  parameter logic [7:0] ID2        = 8'h02,
  parameter logic [7:0] ID3        = 8'hC3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_ferr_i,
  output logic              txd_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [2:0]       slot;
  logic             in_map, rd_en, wr_en;
  logic             wr_data, wr_stat, wr_bl, wr_bh, rd_data;
  logic [DIV_W-1:0] baud_q;
  logic             rxie_q, txie_q, ferr_q, ovr_q;
  logic             hold_full_q;
  logic [7:0]       hold_q;
  logic             tx_busy, tx_load, tick;
  logic [7:0]       rx_head;
  logic [CNT_W-1:0] rx_count;
  logic             rx_empty, rx_full, rx_room1;
  logic [7:0]       status;
  logic             unused_lo;

  assign unused_lo = ^addr_i[1:0];
  assign slot      = addr_i[4:2];
  assign in_map    = (addr_i[ADDR_W-1:5] == '0);
  assign rd_en     = sel_i && !we_i && in_map;
  assign wr_en     = sel_i &&  we_i && in_map;
  assign wr_data   = wr_en && (slot == SLOT_DATA);
  assign wr_stat   = wr_en && (slot == SLOT_STAT);
  assign wr_bl     = wr_en && (slot == SLOT_BAUDL);
  assign wr_bh     = wr_en && (slot == SLOT_BAUDH);
  assign rd_data   = rd_en && (slot == SLOT_DATA);

  always_comb begin
    status            = '0;
    status[ST_FERR]   = ferr_q;
    status[ST_OVR]    = ovr_q;
    status[ST_RXIE]   = rxie_q;
    status[ST_FULL]   = rx_full;
    status[ST_ROOM1]  = rx_room1;
    status[ST_RXEMP]  = rx_empty;
    status[ST_TXIE]   = txie_q;
    status[ST_TXEMP]  = !hold_full_q;
  end

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      unique case (slot)
        SLOT_ID0:   rdata_o = ID0;
        SLOT_ID1:   rdata_o = ID1;
        SLOT_ID2:   rdata_o = ID2;
        SLOT_ID3:   rdata_o = ID3;
        SLOT_DATA:  rdata_o = rx_empty ? 8'h00 : rx_head;
        SLOT_STAT:  rdata_o = status;
        SLOT_BAUDL: rdata_o = baud_q[7:0];
        SLOT_BAUDH: rdata_o = baud_q[15:8];
        default:    rdata_o = '0;
      endcase
    end
  end

  // control and sticky error bits; a hardware set wins over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_q <= '0;
      rxie_q <= 1'b0;
      txie_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_bl) baud_q[7:0]  <= wdata_i;
      if (wr_bh) baud_q[15:8] <= wdata_i;
      if (wr_stat) begin
        rxie_q <= wdata_i[ST_RXIE];
        txie_q <= wdata_i[ST_TXIE];
      end
      ferr_q <= (rx_valid_i && rx_ferr_i) ||
                (ferr_q && !(wr_stat && !wdata_i[ST_FERR]));
      ovr_q  <= (rx_valid_i && rx_full) ||
                (ovr_q && !(wr_stat && !wdata_i[ST_OVR]));
    end
  end

  assign tx_load = hold_full_q && !tx_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (tx_load) begin
      hold_full_q <= 1'b0;
    end else if (wr_data && !hold_full_q) begin
      hold_full_q <= 1'b1;
      hold_q      <= wdata_i;
    end
  end

  sio_tick_gen #(.W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_busy),
    .div_i  (baud_q),
    .tick_o (tick)
  );

  sio_tx_shift u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tx_load),
    .data_i (hold_q),
    .tick_i (tick),
    .busy_o (tx_busy),
    .txd_o  (txd_o)
  );

  sio_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .pop_i   (rd_data),
    .head_o  (rx_head),
    .count_o (rx_count),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .room1_o (rx_room1)
  );

  assign irq_o = (rxie_q && (!rx_empty || ferr_q || ovr_q)) ||
                 (txie_q && !hold_full_q);
endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk
  import sio_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              rx_valid_i,
  input logic              rx_ferr_i,
  input logic              txd_o,
  input logic              irq_o,
  input logic              ferr_q,
  input logic              ovr_q,
  input logic              txie_q,
  input logic              hold_full_q,
  input logic [7:0]        hold_q,
  input logic              tx_busy,
  input logic              rx_full,
  input logic [CNT_W-1:0]  rx_count
);
  logic wr_data_a, wr_stat_a;
  assign wr_data_a = sel_i && we_i && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(SLOT_DATA));
  assign wr_stat_a = sel_i && we_i && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(SLOT_STAT));

  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  a_r5_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && wr_data_a) |=> $stable(hold_q));

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CNT_W'(FIFO_DEPTH));

  a_r7_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_full) |=> ovr_q);

  a_r8_frame_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ferr_i) |=> ferr_q);

  a_r9_ferr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_q && !(wr_stat_a && !wdata_i[ST_FERR])) |=> ferr_q);

  a_r10_irq_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txie_q && !hold_full_q) |-> irq_o);
endmodule

bind sio_regfile sio_regfile_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rx_valid_i  (rx_valid_i),
  .rx_ferr_i   (rx_ferr_i),
  .txd_o       (txd_o),
  .irq_o       (irq_o),
  .ferr_q      (ferr_q),
  .ovr_q       (ovr_q),
  .txie_q      (txie_q),
  .hold_full_q (hold_full_q),
  .hold_q      (hold_q),
  .tx_busy     (tx_busy),
  .rx_full     (rx_full),
  .rx_count    (rx_count)
);

// File: tb/tb_sio_regfile.sv
module tb_sio_regfile;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, we_i = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_ferr_i = 1'b0;
  logic       txd_o, irq_o;

  int n_chk = 0, n_err = 0, frames = 0;
  int div_model = 0;
  logic mon_busy = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  sio_regfile dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FIFO? no: FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    sel_i = 0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, e);
  endtask

  task automatic rx_push(input logic [7:0] d, input logic fe);
    @(negedge clk_i);
    rx_valid_i = 1; rx_data_i = d; rx_ferr_i = fe;
    @(negedge clk_i);
    rx_valid_i = 0; rx_ferr_i = 0;
  endtask

  // driver side of the scoreboard
  task automatic send(input logic [7:0] d, input bit accepted);
    wr(6'd16, d);
    if (accepted) exp_q.push_back(d);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0 && !mon_busy);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // monitor: decode serial frames, compare against queue (R4)
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && txd_o === 1'b0) begin
        int bc;
        logic [7:0] got;
        logic [7:0] e;
        mon_busy = 1;
        bc = 4 * (div_model + 1);
        repeat (bc / 2) @(negedge clk_i);
        chk("R4 start bit", txd_o, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (bc) @(negedge clk_i);
          got[i] = txd_o;
        end
        repeat (bc) @(negedge clk_i);
        chk("R4 stop bit", txd_o, 1);
        frames++;
        if (exp_q.size() == 0) begin
          chk("R5 unexpected frame", got, 'h100);
        end else begin
          e = exp_q.pop_front();
          chk("R4 frame data", got, e);
        end
        mon_busy = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++; n_chk++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk("R1 txd idle", txd_o, 1);
    chk("R1 irq", irq_o, 0);
    rd_chk("R1 status", 6'd20, 8'hA0);
    rd_chk("R1 baud lo", 6'd24, 8'h00);
    rd_chk("R1 baud hi", 6'd28, 8'h00);
    // R2 identification
    rd_chk("R2 id0", 6'd0, 8'h5A);
    rd_chk("R2 id1", 6'd4, 8'h10);
    rd_chk("R2 id2", 6'd8, 8'h02);
    rd_chk("R2 id3", 6'd12, 8'hC3);
    wr(6'd4, 8'hFF);
    rd_chk("R2 id1 after write", 6'd4, 8'h10);
    // R3 divisor and reserved space
    wr(6'd28, 8'h12);
    rd_chk("R3 baud hi", 6'd29, 8'h12);
    wr(6'd28, 8'h00);
    wr(6'd32, 8'h77);
    rd_chk("R3 reserved", 6'd32, 8'h00);
    rd_chk("R3 baud lo unchanged", 6'd24, 8'h00);
    wr(6'd24, 8'h01);
    div_model = 1;
    rd_chk("R3 baud lo", 6'd24, 8'h01);
    // R4/R5 transmit, one-entry holding
    send(8'hA5, 1);
    send(8'h3C, 1);
    rd_chk("R5 txempty low", 6'd20, 8'h20);
    send(8'hEE, 0);
    drain();
    chk("R5 frame count", frames, 2);
    rd_chk("R5 txempty high", 6'd20, 8'hA0);
    // R10 transmit interrupt
    wr(6'd20, 8'h40);
    #1 chk("R10 tx irq", irq_o, 1);
    wr(6'd20, 8'h00);
    #1 chk("R10 tx irq off", irq_o, 0);
    // R4 second divisor
    wr(6'd24, 8'h02);
    div_model = 2;
    send(8'h81, 1);
    send(8'h5E, 1);
    drain();
    chk("R4 frame count", frames, 4);
    // R6 fifo fill
    rx_push(8'h11, 0);
    rx_push(8'h22, 0);
    rx_push(8'h33, 0);
    rd_chk("R6 room for one", 6'd20, 8'h90);
    rx_push(8'h44, 0);
    rd_chk("R6 full", 6'd20, 8'h88);
    // R7 overrun
    rx_push(8'h55, 0);
    rd_chk("R7 overrun", 6'd20, 8'h8A);
    chk("R10 irq masked", irq_o, 0);
    wr(6'd20, 8'h07);
    rd_chk("R9 keep errors", 6'd20, 8'h8E);
    chk("R10 rx irq", irq_o, 1);
    wr(6'd20, 8'h05);
    rd_chk("R9 clear overrun", 6'd20, 8'h8C);
    rd_chk("R6 pop 1", 6'd16, 8'h11);
    rd_chk("R6 pop 2", 6'd16, 8'h22);
    rd_chk("R6 pop 3", 6'd16, 8'h33);
    rd_chk("R7 pop 4 not 55", 6'd16, 8'h44);
    rd_chk("R6 empty", 6'd20, 8'hA4);
    rd_chk("R6 empty read", 6'd16, 8'h00);
    rd_chk("R6 still empty", 6'd20, 8'hA4);
    chk("R10 no cause", irq_o, 0);
    // R8 framing error
    rx_push(8'h66, 1);
    rd_chk("R8 frame flag", 6'd20, 8'h85);
    chk("R10 rx data irq", irq_o, 1);
    rd_chk("R8 stored", 6'd16, 8'h66);
    rd_chk("R8 flag sticky", 6'd20, 8'hA5);
    chk("R10 err irq", irq_o, 1);
    wr(6'd20, 8'h04);
    rd_chk("R9 clear frame", 6'd20, 8'hA4);
    chk("R10 cleared", irq_o, 0);
    wr(6'd20, 8'hFF);
    rd_chk("R9 hw bits ignore write", 6'd20, 8'hE4);
    wr(6'd20, 8'h00);
    rd_chk("R9 enables off", 6'd20, 8'hA0);
    finish_run();
  end
endmodule